// File: doc/BRIEF.md
# BCD Time-of-Day Counter with 12/24-Hour Hours Register

This block keeps the time of day as three packed-BCD bytes (seconds, minutes, hours). It advances by one second on each single-cycle `tick` pulse. Seconds roll into minutes and minutes roll into hours. The hours byte carries its own format: bit 7 chooses 12-hour or 24-hour counting, and bit 5 is either the PM flag or the "2" of the tens-of-hours digit, depending on that choice. When the hours wrap past midnight, the block raises a one-cycle `day_carry` pulse for a calendar stage downstream. It does not count date, month or year itself.

Committed time data enters through a valid/ready load port that replaces all three bytes at once. The block never applies back-pressure: `ld_ready` is held high. A load is therefore taken on every clock edge where `ld_valid` is high, and the source must hold the data only for that cycle. Loaded bytes must be valid BCD for the selected format. A combinational read port returns any register in its stored encoding.

Top module: `bcd_time_keeper`

## Requirements
- R1: After reset, seconds, minutes and hours read 8'h00, which is 24-hour mode at midnight, and `day_carry` is 0.
- R2: `rd_sel` selects the byte on `rd_data` in the same cycle: 0 gives seconds, 1 gives minutes, 2 gives hours and 3 gives 8'h00. Bit 7 of seconds and minutes and bit 6 of hours always read 0, whatever value was loaded there.
- R3: Each `tick` without a load adds one second in BCD. The low nibble holds units and bits 6:4 hold tens, so 8'h09 becomes 8'h10 and 8'h59 becomes 8'h00.
- R4: When seconds wrap from 8'h59, minutes advance by one in the same BCD format. Minutes wrap from 8'h59 to 8'h00, and that wrap advances the hours.
- R5: With hours bit 7 = 0 (24-hour mode), bits 5:0 count in BCD from 00 to 23, with bit 5 as the tens "2". The sequence steps 09 to 10, 19 to 20, and 23 to 00.
- R6: With hours bit 7 = 1 (12-hour mode), bits 4:0 count 12, 01, 02 … 11 and bit 5 is PM (1 = PM). Stepping 11 to 12 toggles PM. Stepping 12 to 01 keeps PM unchanged. Bit 7 stays 1.
- R7: `day_carry` is high for exactly the one cycle after the edge that wraps the day. In 24-hour mode the wrap is 23 to 00. In 12-hour mode the wrap is 11 PM to 12 AM only, and 11 AM to 12 PM gives no carry.
- R8: `ld_ready` is always 1. A cycle with `ld_valid` high loads all three bytes at the next edge, even if `tick` is high in the same cycle. That tick is dropped and no `day_carry` follows.
- R9: In a cycle with neither `tick` nor `ld_valid`, all three registers hold their values.
- R10: The hours format bit changes only through a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance pulse |
| ld_valid | input | 1 | Load request for all three bytes |
| ld_ready | output | 1 | Load acceptance, always 1 |
| ld_sec | input | 8 | Seconds byte to load |
| ld_min | input | 8 | Minutes byte to load |
| ld_hour | input | 8 | Hours byte to load (bit 7 format, bit 5 PM or tens "2") |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 8 | Selected register byte |
| day_carry | output | 1 | One-cycle pulse on day wrap |

## Verification
A tick or a load changes the registers at the very next clock edge. `day_carry` is registered on that same edge, so every result is due exactly one cycle after its stimulus, and `rd_data` follows `rd_sel` with no delay. The bench drives inputs at the falling edge and advances its reference model at the rising edge. Before driving the next cycle, it compares all four read selections, `day_carry` and `ld_ready` at the following falling edge. Every cycle is therefore checked at the one point where its result is due.

// File: rtl/bcd_clk_pkg.sv
`timescale 1ns/1ps
package bcd_clk_pkg;
  localparam int BYTE_W  = 8;
  localparam int MS_W    = 7;
  localparam int NUM_MS  = 2;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_HOUR = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  // Hours byte field positions (behavioural: decoded by counter and reader)
  localparam int HR_FMT_BIT = 7;
  localparam int HR_PM_BIT  = 5;
endpackage

// File: rtl/bcd_ms_counter.sv
`timescale 1ns/1ps
module bcd_ms_counter
  import bcd_clk_pkg::*;
#(
  parameter logic [MS_W-1:0] LAST = 7'h59
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            load,
  input  logic [MS_W-1:0] ld_val,
  output logic [MS_W-1:0] val,
  output logic            wrap
);
  localparam int UNIT_W = 4;
  localparam int TENS_W = MS_W - UNIT_W;

  logic [MS_W-1:0] cnt_q;
  logic [MS_W-1:0] cnt_nxt;
  logic            at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap    = inc & at_last;

  always_comb begin
    cnt_nxt = cnt_q;
    if (at_last) begin
      cnt_nxt = '0;
    end else if (cnt_q[UNIT_W-1:0] == 4'd9) begin
      cnt_nxt[UNIT_W-1:0]    = '0;
      cnt_nxt[MS_W-1:UNIT_W] = cnt_q[MS_W-1:UNIT_W] + TENS_W'(1);
    end else begin
      cnt_nxt[UNIT_W-1:0] = cnt_q[UNIT_W-1:0] + UNIT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= ld_val;
    else if (inc)   cnt_q <= cnt_nxt;
  end

  assign val = cnt_q;
endmodule

// File: rtl/bcd_hour_counter.sv
`timescale 1ns/1ps
module bcd_hour_counter
  import bcd_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              load,
  input  logic [BYTE_W-1:0] ld_val,
  output logic [BYTE_W-1:0] hour,
  output logic              day_wrap
);
  logic [BYTE_W-1:0] hr_q;
  logic [BYTE_W-1:0] hr_nxt;
  logic              wrap_c;

  always_comb begin
    hr_nxt = hr_q;
    wrap_c = 1'b0;
    if (hr_q[HR_FMT_BIT]) begin
      // 12-hour: bits 4:0 run 12,01..11; bit 5 is PM
      if (hr_q[4:0] == 5'h12) begin
        hr_nxt[4:0] = 5'h01;
      end else if (hr_q[4:0] == 5'h11) begin
        hr_nxt[4:0]      = 5'h12;
        hr_nxt[HR_PM_BIT] = ~hr_q[HR_PM_BIT];
        wrap_c           = hr_q[HR_PM_BIT];
      end else if (hr_q[3:0] == 4'd9) begin
        hr_nxt[4:0] = 5'h10;
      end else begin
        hr_nxt[3:0] = hr_q[3:0] + 4'd1;
      end
    end else begin
      // 24-hour: bits 5:0 run 00..23
      if (hr_q[5:0] == 6'h23) begin
        hr_nxt[5:0] = '0;
        wrap_c      = 1'b1;
      end else if (hr_q[3:0] == 4'd9) begin
        hr_nxt[3:0] = '0;
        hr_nxt[5:4] = hr_q[5:4] + 2'd1;
      end else begin
        hr_nxt[3:0] = hr_q[3:0] + 4'd1;
      end
    end
  end

  assign day_wrap = inc & wrap_c;

  always_ff @(posedge clk) begin
    if (!rst_n)     hr_q <= '0;
    else if (load)  hr_q <= {ld_val[7], 1'b0, ld_val[5:0]};
    else if (inc)   hr_q <= hr_nxt;
  end

  assign hour = hr_q;
endmodule

// File: rtl/bcd_time_keeper.sv
`timescale 1ns/1ps
module bcd_time_keeper
  import bcd_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [BYTE_W-1:0] ld_sec,
  input  logic [BYTE_W-1:0] ld_min,
  input  logic [BYTE_W-1:0] ld_hour,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              day_carry
);
  localparam logic ALWAYS_READY = 1'b1;

  logic              load_go;
  logic [NUM_MS:0]   inc_chain;
  logic [MS_W-1:0]   ms_val  [NUM_MS];
  logic [MS_W-1:0]   ms_ld   [NUM_MS];
  logic [NUM_MS-1:0] ms_wrap;
  logic [MS_W-1:0]   sec_val;
  logic [MS_W-1:0]   min_val;
  logic [BYTE_W-1:0] hour_val;
  logic              hour_wrap;
  logic              carry_q;

  assign ld_ready     = ALWAYS_READY;
  assign load_go      = ld_valid & ld_ready;
  assign inc_chain[0] = tick & ~load_go;
  assign ms_ld[0]     = ld_sec[MS_W-1:0];
  assign ms_ld[1]     = ld_min[MS_W-1:0];

  for (genvar g = 0; g < NUM_MS; g++) begin : g_ms
    bcd_ms_counter #(.LAST(7'h59)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc_chain[g]),
      .load   (load_go),
      .ld_val (ms_ld[g]),
      .val    (ms_val[g]),
      .wrap   (ms_wrap[g])
    );
    assign inc_chain[g+1] = ms_wrap[g];
  end

  assign sec_val = ms_val[0];
  assign min_val = ms_val[1];

  bcd_hour_counter u_hour (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc_chain[NUM_MS]),
    .load     (load_go),
    .ld_val   (ld_hour),
    .hour     (hour_val),
    .day_wrap (hour_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= hour_wrap;
  end
  assign day_carry = carry_q;

  always_comb begin
    unique case (rd_sel_e'(rd_sel))
      SEL_SEC:  rd_data = {1'b0, sec_val};
      SEL_MIN:  rd_data = {1'b0, min_val};
      SEL_HOUR: rd_data = hour_val;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/bcd_time_keeper_chk.sv
`timescale 1ns/1ps
module bcd_time_keeper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ld_valid,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_min,
  input logic [7:0] ld_hour,
  input logic [1:0] rd_sel,
  input logic [7:0] rd_data,
  input logic       day_carry,
  input logic [6:0] sec_val,
  input logic [6:0] min_val,
  input logic [7:0] hour_val
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (sec_val == $past(ld_sec[6:0])) && (min_val == $past(ld_min[6:0]))
                 && (hour_val == {$past(ld_hour[7]), 1'b0, $past(ld_hour[5:0])})); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_valid) |=> $stable(sec_val) && $stable(min_val) && $stable(hour_val)); // R9
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_valid && sec_val == 7'h59) |=> sec_val == 7'h00); // R3
  AST_MIN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_valid && sec_val == 7'h59) |=> min_val != $past(min_val)); // R4
  AST_CARRY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |-> $past(tick) && !$past(ld_valid)); // R7
  AST_CARRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> !day_carry); // R7
  AST_FMT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> hour_val[7] == $past(hour_val[7])); // R10
  AST_H24_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !hour_val[7] |-> hour_val[5:0] <= 6'h23); // R5
  AST_RD_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == 2'd3 |-> rd_data == 8'h00); // R2
endmodule

bind bcd_time_keeper bcd_time_keeper_chk u_chk (.*);

// File: tb/bcd_time_keeper_tb.sv
`timescale 1ns/1ps
module bcd_time_keeper_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       day_carry;

  int checks = 0;
  int errors = 0;

  // reference model state (binary)
  int ms, mm, mh;
  bit m12, mpm, mcarry;

  always #2 clk = ~clk;

  bcd_time_keeper u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
    .rd_sel(rd_sel), .rd_data(rd_data), .day_carry(day_carry)
  );

  function automatic logic [7:0] to_bcd(int x);
    return 8'(((x / 10) * 16) + (x % 10));
  endfunction

  function automatic int from_bcd(logic [3:0] tens, logic [3:0] units);
    return int'(tens) * 10 + int'(units);
  endfunction

  function automatic logic [7:0] enc_hour(bit f12, bit pm, int h);
    logic [7:0] b;
    b = to_bcd(h);
    if (f12) b = b | 8'h80 | (pm ? 8'h20 : 8'h00);
    return b;
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    for (int k = 0; k < 4; k++) begin
      rd_sel = 2'(k);
      #0.2;
      case (k)
        0: chk(rd_data, to_bcd(ms), tag);
        1: chk(rd_data, to_bcd(mm), tag);
        2: chk(rd_data, enc_hour(m12, mpm, mh), tag);
        default: chk(rd_data, 8'h00, "R2");
      endcase
    end
    chk({7'd0, day_carry}, {7'd0, mcarry}, (tag == "R7") ? "R7" : "R7 carry");
    chk({7'd0, ld_ready}, 8'h01, "R8 ready");
  endtask

  task automatic model_step(bit t, bit l, logic [7:0] s, logic [7:0] m, logic [7:0] h);
    mcarry = 0;
    if (l) begin
      ms  = from_bcd({1'b0, s[6:4]}, s[3:0]);
      mm  = from_bcd({1'b0, m[6:4]}, m[3:0]);
      m12 = h[7];
      if (h[7]) begin
        mpm = h[5];
        mh  = from_bcd({3'b0, h[4]}, h[3:0]);
      end else begin
        mpm = 0;
        mh  = from_bcd({2'b0, h[5:4]}, h[3:0]);
      end
    end else if (t) begin
      ms++;
      if (ms == 60) begin
        ms = 0; mm++;
        if (mm == 60) begin
          mm = 0;
          if (!m12) begin
            if (mh == 23) begin mh = 0; mcarry = 1; end else mh++;
          end else begin
            if (mh == 12) mh = 1;
            else if (mh == 11) begin
              mh = 12;
              if (mpm) mcarry = 1;
              mpm = ~mpm;
            end else mh++;
          end
        end
      end
    end
  endtask

  // called at a falling edge: drive, let the rising edge pass, compare at next falling edge
  task automatic cyc(bit t, bit l, logic [7:0] s, logic [7:0] m, logic [7:0] h, string tag);
    tick = t; ld_valid = l; ld_sec = s; ld_min = m; ld_hour = h;
    @(posedge clk);
    model_step(t, l, s, m, h);
    @(negedge clk);
    tick = 0; ld_valid = 0;
    compare(tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ms = 0; mm = 0; mh = 0; m12 = 0; mpm = 0; mcarry = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1");

    // 24-hour units/tens rollovers, R3 R4 R5
    cyc(0, 1, 8'h58, 8'h59, 8'h09, "R8");
    cyc(1, 0, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, 0, "R5");
    // masked bits on load, R2; 19 -> 20
    cyc(0, 1, 8'hD8, 8'hD9, 8'h59, "R2");
    cyc(1, 0, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, 0, "R5");
    // midnight wrap, R7
    cyc(0, 1, 8'h59, 8'h59, 8'h23, "R8");
    cyc(1, 0, 0, 0, 0, "R7");
    // hold, R9
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, "R9");
    // 12-hour: 11 AM -> 12 PM no carry
    cyc(0, 1, 8'h59, 8'h59, 8'h91, "R8");
    cyc(1, 0, 0, 0, 0, "R6");
    // 11 PM -> 12 AM carry
    cyc(0, 1, 8'h59, 8'h59, 8'hB1, "R8");
    cyc(1, 0, 0, 0, 0, "R7");
    // 12 -> 01 keeps PM
    cyc(0, 1, 8'h59, 8'h59, 8'hB2, "R8");
    cyc(1, 0, 0, 0, 0, "R6");
    // 09 -> 10 in 12-hour
    cyc(0, 1, 8'h59, 8'h59, 8'h89, "R8");
    cyc(1, 0, 0, 0, 0, "R6");
    // format kept over many ticks, R10
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, "R10");
    // load and tick together: load wins, no carry, R8
    cyc(0, 1, 8'h59, 8'h59, 8'h23, "R8");
    cyc(1, 1, 8'h59, 8'h59, 8'h23, "R8");
    cyc(1, 1, 8'h10, 8'h20, 8'hA5, "R8");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 40) == 0) begin
        bit f; bit p; int s; int m; int h;
        f = 1'($urandom % 2);
        p = 1'($urandom % 2);
        s = (($urandom % 3) == 0) ? int'($urandom % 60) : 58 + int'($urandom % 2);
        m = (($urandom % 2) == 0) ? 59 : int'($urandom % 60);
        h = f ? 1 + int'($urandom % 12) : int'($urandom % 24);
        cyc(1'($urandom % 2), 1, to_bcd(s), to_bcd(m), enc_hour(f, f ? p : 1'b0, h), "R8");
      end else begin
        cyc(1'($urandom % 2), 0, 0, 0, 0, "R4");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule